// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and turns them into two active-high requests for a processor: a normal request and a fast request. Software configures it through a small word-addressed register bus. Each line can be routed to either request class and given a 4-bit priority. A line is switched on or off by writing its number to a command register. This avoids a read-modify-write of a bitmask.

For normal requests, a registered comparison tree picks one winner. The winner is the line with the highest priority, and among equal priorities the higher line number wins. A threshold register hides low-priority work. Software reads the winner's number and priority from a status word. In vectored mode, the controller also presents the handler address stored for that winner in a 64-word table. Fast requests skip priority entirely. A second status word names the highest-numbered pending fast line.

Top module: `vec_intc`

## Requirements
- R1: After reset, control, mask, both type words and all priority words read 0. All sources are disabled. `irq_req`, `fiq_req` and `irq_vector` are 0, and both status words read 0xFFFFFFFF.
- R2: A write of value n (n < 64) to offset 0x08 enables source n, and a write of n to offset 0x0C disables it. No other source changes. A written value of 64 or more changes nothing.
- R3: The type word at 0x14 holds sources 31..0 and the word at 0x10 holds sources 63..32, with source n at bit n mod 32. A 1 routes the source to the fast class and a 0 to the normal class. Both words read back as written.
- R4: Priority words sit at 0x20 + 4k for k = 0..7. Source n occupies word k = 7 − (n >> 3), bits (n & 7)·4 +: 4. The words read back as written.
- R5: A normal source competes when its input is high, it is enabled, its type is normal and it passes the mask. The competitor with the highest priority wins, and a tie goes to the higher source number. `irq_req` is high exactly when a winner exists. Both are registered, so they follow an input or register change at the next rising clock edge.
- R6: The 5-bit mask at 0x04 lets a source through only when its priority, taken as a non-negative number, is greater than the mask read as a signed 5-bit value. So mask 0 blocks priority 0, and any mask from 0x10 to 0x1F blocks nothing.
- R7: The normal status word at 0x40 holds the winner's number in bits 31:16 and its priority in bits 15:0. It reads 0xFFFFFFFF when there is no winner.
- R8: The fast status word at 0x44 holds the highest-numbered source that is high, enabled and of fast type, or 0xFFFFFFFF when there is none. `fiq_req` is high exactly when such a source exists, one edge after the cause. The mask and the priorities have no effect on the fast class.
- R9: Vector table entry n at byte address 0x100 + 4n reads back exactly the 32-bit value last written to it.
- R10: Bit 0 of the control word at 0x00 selects vectored mode. While it is 1 and `irq_req` is high, `irq_vector` equals the table entry of the current winner. Otherwise `irq_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W (9) | Byte address; the low two bits are ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from `bus_addr`; 0 when not selected |
| src_i | input | NUM_SRC (64) | Interrupt source levels, active high |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |
| irq_vector | output | DATA_W (32) | Handler address of the normal winner in vectored mode |

## Verification
The bench puts two normal sources at equal priority. A tree that keeps the lower index on ties would then report the wrong winner. It also steps the mask across the boundary where a source's priority equals the mask value, and uses a mask with the top bit set. A design that compared unsigned, or used less-than-or-equal the wrong way round, would drop or admit sources at the edge. The priority nibbles are checked through the winner's reported priority, not only by read-back, so a word or nibble order that is reversed shows up in arbitration. The bench also writes a source number of 64 and disables a source that is not pending, to catch number decoders that alias or disturb neighbours. It samples `irq_req` just before and just after the clock edge that follows a line change, to pin down the one-cycle latency.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
   // Register byte offsets inside the low 256-byte window
   localparam logic [7:0] OFS_CTRL    = 8'h00;
   localparam logic [7:0] OFS_MASK    = 8'h04;
   localparam logic [7:0] OFS_ENNUM   = 8'h08;
   localparam logic [7:0] OFS_DISNUM  = 8'h0C;
   localparam logic [7:0] OFS_TYPE_HI = 8'h10;
   localparam logic [7:0] OFS_TYPE_LO = 8'h14;
   localparam logic [7:0] OFS_PRIO0   = 8'h20;
   localparam logic [7:0] OFS_NSTAT   = 8'h40;
   localparam logic [7:0] OFS_FSTAT   = 8'h44;
   // Bit that separates the register window from the vector table
   localparam int VEC_SEL_BIT = 8;

   typedef enum logic {SRC_NORMAL = 1'b0, SRC_FAST = 1'b1} src_class_e;
endpackage

// File: rtl/vec_intc_tree.sv
// Pairwise maximum tree: returns the largest key among valid leaves.
module vec_intc_tree #(
   parameter int N     = 64,
   parameter int KEY_W = 10
) (
   input  logic [N-1:0]       leaf_v,
   input  logic [N*KEY_W-1:0] leaf_key,
   output logic               win_v,
   output logic [KEY_W-1:0]   win_key
);
   localparam int LVLS = (N > 1) ? $clog2(N) : 1;
   localparam int NP   = 1 << LVLS;

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      logic [KEY_W:0] nd [NP >> l];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < NP; i++) begin : g_in
            if (i < N) begin : g_real
               assign nd[i] = {leaf_v[i], leaf_v[i] ? leaf_key[i*KEY_W +: KEY_W] : {KEY_W{1'b0}}};
            end else begin : g_pad
               assign nd[i] = '0;
            end
         end
      end else begin : g_node
         for (genvar i = 0; i < (NP >> l); i++) begin : g_cmp
            assign nd[i] = (g_lvl[l-1].nd[2*i+1] > g_lvl[l-1].nd[2*i]) ?
                           g_lvl[l-1].nd[2*i+1] : g_lvl[l-1].nd[2*i];
         end
      end
   end

   assign win_v   = g_lvl[LVLS].nd[0][KEY_W];
   assign win_key = g_lvl[LVLS].nd[0][KEY_W-1:0];
endmodule

// File: rtl/vec_intc_vram.sv
// Handler address table: one write port, two combinational read ports.
module vec_intc_vram #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IDX_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/vec_intc_cfg.sv
// Per-source enable, class and priority storage plus control and mask.
module vec_intc_cfg
   import vec_intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [7:0]                ofs,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic [NUM_SRC-1:0]        en_vec,
   output logic [NUM_SRC-1:0]        fiq_vec,
   output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic                      vec_mode,
   output logic [PRIO_W:0]           mask_q
);
   localparam int PER_REG   = DATA_W / PRIO_W;
   localparam int PRIO_REGS = NUM_SRC / PER_REG;

   logic [63:0] fiq_pad;
   assign fiq_pad = 64'(fiq_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_mode <= 1'b0;
         mask_q   <= '0;
      end else if (wr_en) begin
         if (ofs == OFS_CTRL) vec_mode <= wdata[0];
         if (ofs == OFS_MASK) mask_q   <= wdata[PRIO_W:0];
      end
   end

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      localparam logic [7:0] TYPE_OFS = (n >= 32) ? OFS_TYPE_HI : OFS_TYPE_LO;
      localparam int         PREG     = PRIO_REGS - 1 - (n / PER_REG);
      localparam logic [7:0] PRIO_OFS = 8'(int'(OFS_PRIO0) + 4 * PREG);
      localparam int         NIB      = (n % PER_REG) * PRIO_W;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_vec[n]                      <= 1'b0;
            fiq_vec[n]                     <= SRC_NORMAL;
            prio_flat[n*PRIO_W +: PRIO_W]  <= '0;
         end else if (wr_en) begin
            if (ofs == OFS_ENNUM  && wdata == DATA_W'(n)) en_vec[n] <= 1'b1;
            if (ofs == OFS_DISNUM && wdata == DATA_W'(n)) en_vec[n] <= 1'b0;
            if (ofs == TYPE_OFS) fiq_vec[n] <= wdata[n % 32];
            if (ofs == PRIO_OFS) prio_flat[n*PRIO_W +: PRIO_W] <= wdata[NIB +: PRIO_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (ofs)
         OFS_CTRL:    rdata[0]        = vec_mode;
         OFS_MASK:    rdata[PRIO_W:0] = mask_q;
         OFS_TYPE_LO: rdata           = DATA_W'(fiq_pad[31:0]);
         OFS_TYPE_HI: rdata           = DATA_W'(fiq_pad[63:32]);
         default: begin
            for (int k = 0; k < PRIO_REGS; k++) begin
               if (ofs == 8'(int'(OFS_PRIO0) + 4 * k)) begin
                  for (int j = 0; j < PER_REG; j++) begin
                     rdata[j*PRIO_W +: PRIO_W] =
                        prio_flat[((PRIO_REGS - 1 - k) * PER_REG + j) * PRIO_W +: PRIO_W];
                  end
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
   import vec_intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_req,
   output logic               fiq_req,
   output logic [DATA_W-1:0]  irq_vector
);
   localparam int SRC_W  = $clog2(NUM_SRC);
   localparam int KEY_W  = PRIO_W + SRC_W;
   localparam int HALF_W = DATA_W / 2;

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 64) begin : g_bad_src
      $error("vec_intc: NUM_SRC must be 32 or 64");
   end
   if (DATA_W != 32 || DATA_W % PRIO_W != 0) begin : g_bad_data
      $error("vec_intc: DATA_W must be 32 and a multiple of PRIO_W");
   end
   if (ADDR_W < VEC_SEL_BIT + 1) begin : g_bad_addr
      $error("vec_intc: ADDR_W too small for the vector table");
   end

   // Bus decode
   logic       reg_hit, vec_hit, wr_en;
   logic [7:0] ofs;
   assign reg_hit = (bus_addr[ADDR_W-1:VEC_SEL_BIT] == '0);
   assign vec_hit = (bus_addr[ADDR_W-1:VEC_SEL_BIT] == (ADDR_W-VEC_SEL_BIT)'(1));
   assign wr_en   = bus_sel && bus_wr;
   assign ofs     = {bus_addr[7:2], 2'b00};

   // Configuration storage
   logic [NUM_SRC-1:0]        en_vec, fiq_vec;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      vec_mode;
   logic [PRIO_W:0]           mask_q;
   logic [DATA_W-1:0]         cfg_rdata;

   vec_intc_cfg #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && reg_hit), .ofs(ofs),
      .wdata(bus_wdata), .rdata(cfg_rdata), .en_vec(en_vec), .fiq_vec(fiq_vec),
      .prio_flat(prio_flat), .vec_mode(vec_mode), .mask_q(mask_q)
   );

   // Leaf qualification
   logic [NUM_SRC-1:0]       irq_elig, fiq_elig;
   logic [NUM_SRC*KEY_W-1:0] irq_keys;
   logic [NUM_SRC*SRC_W-1:0] fiq_keys;

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_leaf
      logic [PRIO_W-1:0] p;
      logic              over_mask;
      assign p         = prio_flat[n*PRIO_W +: PRIO_W];
      assign over_mask = $signed({1'b0, p}) > $signed(mask_q);
      assign irq_elig[n] = src_i[n] && en_vec[n] && (fiq_vec[n] == SRC_NORMAL) && over_mask;
      assign fiq_elig[n] = src_i[n] && en_vec[n] && (fiq_vec[n] == SRC_FAST);
      assign irq_keys[n*KEY_W +: KEY_W] = {p, SRC_W'(n)};
      assign fiq_keys[n*SRC_W +: SRC_W] = SRC_W'(n);
   end

   // Arbitration
   logic             irq_win_v, fiq_win_v;
   logic [KEY_W-1:0] irq_win_key;
   logic [SRC_W-1:0] fiq_win_key;

   vec_intc_tree #(.N(NUM_SRC), .KEY_W(KEY_W)) u_irq_tree (
      .leaf_v(irq_elig), .leaf_key(irq_keys), .win_v(irq_win_v), .win_key(irq_win_key)
   );
   vec_intc_tree #(.N(NUM_SRC), .KEY_W(SRC_W)) u_fiq_tree (
      .leaf_v(fiq_elig), .leaf_key(fiq_keys), .win_v(fiq_win_v), .win_key(fiq_win_key)
   );

   logic              win_v_q, fiq_v_q;
   logic [SRC_W-1:0]  win_idx_q, fiq_idx_q;
   logic [PRIO_W-1:0] win_prio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_v_q    <= 1'b0;
         win_idx_q  <= '0;
         win_prio_q <= '0;
         fiq_v_q    <= 1'b0;
         fiq_idx_q  <= '0;
      end else begin
         win_v_q    <= irq_win_v;
         win_idx_q  <= irq_win_key[SRC_W-1:0];
         win_prio_q <= irq_win_key[KEY_W-1:SRC_W];
         fiq_v_q    <= fiq_win_v;
         fiq_idx_q  <= fiq_win_key;
      end
   end

   // Vector table
   logic [DATA_W-1:0] vram_bus, vram_win;

   vec_intc_vram #(.DEPTH(NUM_SRC), .DATA_W(DATA_W)) u_vram (
      .clk(clk), .we(wr_en && vec_hit), .waddr(bus_addr[SRC_W+1:2]), .wdata(bus_wdata),
      .raddr_a(bus_addr[SRC_W+1:2]), .rdata_a(vram_bus),
      .raddr_b(win_idx_q), .rdata_b(vram_win)
   );

   // Status words and read mux
   logic [DATA_W-1:0] nstat, fstat;
   assign nstat = win_v_q ? {HALF_W'(win_idx_q), HALF_W'(win_prio_q)} : '1;
   assign fstat = fiq_v_q ? DATA_W'(fiq_idx_q) : '1;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (vec_hit)                 bus_rdata = vram_bus;
         else if (reg_hit) begin
            if (ofs == OFS_NSTAT)      bus_rdata = nstat;
            else if (ofs == OFS_FSTAT) bus_rdata = fstat;
            else                       bus_rdata = cfg_rdata;
         end
      end
   end

   assign irq_req    = win_v_q;
   assign fiq_req    = fiq_v_q;
   assign irq_vector = (vec_mode && win_v_q) ? vram_win : '0;
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
   import vec_intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 9,
   localparam int SRC_W  = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [NUM_SRC-1:0] src_i,
   input logic               irq_req,
   input logic               fiq_req,
   input logic [NUM_SRC-1:0] en_vec,
   input logic [NUM_SRC-1:0] fiq_vec,
   input logic [PRIO_W:0]    mask_q,
   input logic [SRC_W-1:0]   win_idx_q,
   input logic [PRIO_W-1:0]  win_prio_q,
   input logic [SRC_W-1:0]   fiq_idx_q
);
   logic [NUM_SRC-1:0] norm_prev, fast_prev;
   logic               en_wr, dis_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         norm_prev <= '0;
         fast_prev <= '0;
      end else begin
         norm_prev <= src_i & en_vec & ~fiq_vec;
         fast_prev <= src_i & en_vec & fiq_vec;
      end
   end

   assign en_wr  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_ENNUM)
                   && bus_wdata < DATA_W'(NUM_SRC);
   assign dis_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DISNUM)
                   && bus_wdata < DATA_W'(NUM_SRC);

   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq_req && !fiq_req));

   p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> en_vec[$past(bus_wdata[SRC_W-1:0])]);

   p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_wr |=> !en_vec[$past(bus_wdata[SRC_W-1:0])]);

   p_class_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && fiq_req) |-> (win_idx_q != fiq_idx_q));

   p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> norm_prev[win_idx_q]);

   p_mask_passed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ($signed({1'b0, win_prio_q}) > $signed($past(mask_q))));

   p_fast_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_req |-> fast_prev[fiq_idx_q]);
endmodule

bind vec_intc vec_intc_chk #(
   .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_i(src_i),
   .irq_req(irq_req), .fiq_req(fiq_req), .en_vec(en_vec), .fiq_vec(fiq_vec),
   .mask_q(mask_q), .win_idx_q(win_idx_q), .win_prio_q(win_prio_q),
   .fiq_idx_q(fiq_idx_q)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
   localparam int HALF = 2500; // ps, 200 MHz clock

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_i = '0;
   logic        irq_req, fiq_req;
   logic [31:0] irq_vector;

   int n_chk = 0, n_bad = 0;

   // Bench-side model of the programmed state
   bit       m_en   [64];
   bit       m_fiq  [64];
   bit [3:0] m_prio [64];
   bit [4:0] m_mask;

   always #HALF clk = ~clk;

   vec_intc u_vec_intc (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_i(src_i), .irq_req(irq_req), .fiq_req(fiq_req), .irq_vector(irq_vector)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   task automatic set_src(input logic [63:0] s);
      @(negedge clk);
      src_i = s;
      settle();
   endtask

   task automatic en_src(input int n);
      bus_write(9'h008, 32'(n));
      if (n < 64) m_en[n] = 1'b1;
   endtask

   task automatic dis_src(input int n);
      bus_write(9'h00C, 32'(n));
      if (n < 64) m_en[n] = 1'b0;
   endtask

   task automatic set_mask(input logic [4:0] m);
      m_mask = m;
      bus_write(9'h004, 32'(m));
   endtask

   function automatic logic [31:0] prio_word(input int k);
      logic [31:0] w;
      for (int j = 0; j < 8; j++) w[j*4 +: 4] = m_prio[(7 - k) * 8 + j];
      return w;
   endfunction

   task automatic set_prio(input int n, input logic [3:0] p);
      int k;
      m_prio[n] = p;
      k = 7 - (n >> 3);
      bus_write(9'(32'h20 + 4 * k), prio_word(k));
   endtask

   function automatic logic [31:0] type_word(input bit hi);
      logic [31:0] w;
      for (int j = 0; j < 32; j++) w[j] = m_fiq[(hi ? 32 : 0) + j];
      return w;
   endfunction

   task automatic set_type(input int n, input bit fast);
      m_fiq[n] = fast;
      if (n >= 32) bus_write(9'h010, type_word(1'b1));
      else         bus_write(9'h014, type_word(1'b0));
   endtask

   function automatic logic [31:0] exp_nstat();
      int best = -1;
      bit [3:0] bp = '0;
      for (int n = 0; n < 64; n++) begin
         if (src_i[n] && m_en[n] && !m_fiq[n] &&
             $signed({1'b0, m_prio[n]}) > $signed(m_mask)) begin
            if (best < 0 || m_prio[n] >= bp) begin best = n; bp = m_prio[n]; end
         end
      end
      return (best < 0) ? 32'hFFFF_FFFF : {16'(best), 16'(bp)};
   endfunction

   function automatic logic [31:0] exp_fstat();
      int f = -1;
      for (int n = 0; n < 64; n++) if (src_i[n] && m_en[n] && m_fiq[n]) f = n;
      return (f < 0) ? 32'hFFFF_FFFF : 32'(f);
   endfunction

   task automatic check_status(input string req);
      logic [31:0] v, en, ef;
      en = exp_nstat();
      ef = exp_fstat();
      bus_read(9'h040, v);
      check({req, " normal status"}, v, en);
      bus_read(9'h044, v);
      check({req, " fast status"}, v, ef);
      check({req, " irq_req"}, 32'(irq_req), 32'(en != 32'hFFFF_FFFF));
      check({req, " fiq_req"}, 32'(fiq_req), 32'(ef != 32'hFFFF_FFFF));
   endtask

   // R1: reset values
   task automatic t_reset();
      logic [31:0] v;
      bus_read(9'h000, v); check("R1 ctrl", v, 0);
      bus_read(9'h004, v); check("R1 mask", v, 0);
      bus_read(9'h010, v); check("R1 type hi", v, 0);
      bus_read(9'h014, v); check("R1 type lo", v, 0);
      for (int k = 0; k < 8; k++) begin
         bus_read(9'(32'h20 + 4 * k), v); check("R1 prio word", v, 0);
      end
      set_src('1);
      check_status("R1");
      check("R1 irq_vector", irq_vector, 0);
      set_src('0);
   endtask

   // R9: vector table storage
   task automatic t_vectors();
      logic [31:0] v;
      for (int n = 0; n < 64; n++)
         bus_write(9'(32'h100 + 4 * n), 32'hA500_0000 | (n << 8) | n);
      bus_write(9'h100 + 9'(4 * 37), 32'hDEAD_BEEF);
      for (int n = 0; n < 64; n++) begin
         bus_read(9'(32'h100 + 4 * n), v);
         check("R9 vector entry", v, (n == 37) ? 32'hDEAD_BEEF : (32'hA500_0000 | (n << 8) | n));
      end
      bus_write(9'h100 + 9'(4 * 37), 32'hA500_2525);
   endtask

   // R2, R6, R5: enable/disable by number and latency
   task automatic t_enable();
      set_mask(5'h1F);
      @(negedge clk);
      src_i = 64'h1 << 5;
      #1 check("R5 before edge", 32'(irq_req), 0);
      en_src(5);                      // write at this edge, winner one edge later
      check("R5 write edge", 32'(irq_req), 0);
      settle();
      check("R5 after edge", 32'(irq_req), 1);
      check_status("R2 enable 5");
      set_src((64'h1 << 5) | (64'h1 << 9) | 64'h1);
      en_src(64);                     // out of range: nothing changes
      settle();
      check_status("R2 number 64 ignored");
      en_src(9);
      settle();
      check_status("R2 enable 9");
      dis_src(0);                     // not enabled; neighbours untouched
      settle();
      check_status("R2 disable other");
      dis_src(9);
      settle();
      check_status("R2 disable 9");
      bus_write(9'h00C, 32'd69);      // 69 aliases 5 in low bits
      settle();
      check_status("R2 disable 69 ignored");
   endtask

   // R4, R5, R7: priority layout and arbitration
   task automatic t_prio_arb();
      logic [31:0] v;
      for (int n = 0; n < 8; n++) set_prio(n, 4'(n));
      for (int n = 56; n < 64; n++) set_prio(n, 4'(63 - n));
      bus_read(9'h03C, v); check("R4 word 7", v, 32'h7654_3210);
      bus_read(9'h020, v); check("R4 word 0", v, 32'h0123_4567);
      for (int n = 0; n < 64; n++) if (!m_en[n]) en_src(n);
      set_src((64'h1 << 3) | (64'h1 << 60));   // prio 3 vs prio 3: tie
      check_status("R5 tie higher number");
      set_src((64'h1 << 6) | (64'h1 << 60));   // 6 beats 3
      check_status("R5 higher prio wins");
      set_prio(20, 4'hF);
      set_src((64'h1 << 6) | (64'h1 << 20) | (64'h1 << 60));
      check_status("R7 prio 15 winner");
      set_src(64'h1 << 57);
      check_status("R4 source 57");
   endtask

   // R6: mask threshold
   task automatic t_mask();
      set_src((64'h1 << 2) | (64'h1 << 5) | (64'h1 << 6) | 64'h1);
      set_mask(5'd0); settle();  check_status("R6 mask 0");
      set_mask(5'd5); settle();  check_status("R6 mask 5");
      set_mask(5'd6); settle();  check_status("R6 mask 6 blocks all");
      set_mask(5'h10); settle(); check_status("R6 mask 0x10");
      set_src(64'h1);
      set_mask(5'h1F); settle(); check_status("R6 mask 0x1F prio 0");
   endtask

   // R3, R8: fast class
   task automatic t_fast();
      logic [31:0] v;
      set_type(40, 1'b1);
      set_type(3, 1'b1);
      bus_read(9'h010, v); check("R3 type hi", v, 32'h0000_0100);
      bus_read(9'h014, v); check("R3 type lo", v, 32'h0000_0008);
      set_mask(5'd15);
      set_src((64'h1 << 3) | (64'h1 << 40) | (64'h1 << 7));
      check_status("R8 fast unmasked");
      set_src(64'h1 << 3);
      check_status("R8 single fast");
      dis_src(3); settle();
      check_status("R8 disabled fast");
      set_type(40, 1'b0);
      set_mask(5'h1F);
      set_src(64'h1 << 40);
      check_status("R3 back to normal");
   endtask

   // R10: vectored mode
   task automatic t_vectored();
      set_src(64'h1 << 20);
      check("R10 mode off", irq_vector, 0);
      bus_write(9'h000, 32'h1);
      #1 check("R10 mode on", irq_vector, 32'hA500_1414);
      set_src(64'h1 << 37);
      check("R10 follows winner", irq_vector, 32'hA500_2525);
      set_src('0);
      check("R10 no winner", irq_vector, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_vectors();
      t_enable();
      t_prio_arb();
      t_mask();
      t_fast();
      t_vectored();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule